// File: doc/BRIEF.md
# 68008 Bus Glue with Boot Vector Overlay

This block is the glue logic between a 68008-class processor with a 22-bit address bus and an 8-bit expansion backplane. It splits the 4MB address space into four 1MB windows: on-board RAM (two 512KB chips), on-board ROM (two 512KB chips), a backplane memory-request window and a backplane I/O-request window. It turns the single read/write line into separate read and write strobes. It answers memory cycles with DTACK and answers I/O-window cycles with VPA, so that the processor runs a synchronous 6800-style peripheral cycle there. It encodes the two backplane interrupt lines onto the three priority inputs, and it enables the open-drain HALT and RESET drivers while hard reset is applied.

Right after reset, the processor fetches its initial supervisor stack pointer and program counter from the first eight bytes of memory, where RAM normally sits. A small state machine counts completed address-strobe cycles. While it is in the `BOOT_VECTOR` state, the lower RAM chip's range is served by the lower ROM chip. After the eighth completed cycle it takes the `BOOT_VECTOR -> BOOT_RUN` transition, which is its only transition. It stays in `BOOT_RUN` until the next reset, and reset is the only way back to `BOOT_VECTOR`.

The decode, strobe, acknowledge and interrupt outputs are combinational from the pins. Only the overlay state and its counter are clocked.

Top module: `glue68k_top`

## Requirements
- R1: With AS asserted and address bits [21:20] = 00, RAM is selected: `ram_cs[0]` for 0x000000–0x07FFFF and `ram_cs[1]` for 0x080000–0x0FFFFF (bit 19 picks the chip), provided the overlay does not apply.
- R2: With AS asserted and bits [21:20] = 01, ROM is selected: `rom_cs[0]` for 0x100000–0x17FFFF and `rom_cs[1]` for 0x180000–0x1FFFFF.
- R3: With AS asserted, `bus_memrq` is high for 0x200000–0x2FFFFF (bits = 10) and `bus_iorq` is high for 0x300000–0x3FFFFF (bits = 11).
- R4: With AS negated (`cpu_as_n` = 1), every chip select and both request outputs are low, whatever the address.
- R5: `cpu_dtack_n` is 0 exactly when AS and DS are both asserted and the address is in the RAM, ROM or memory-request window.
- R6: `cpu_vpa_n` is 0 exactly when AS is asserted in the I/O-request window. DTACK is never asserted in that window.
- R7: `bus_rd` = DS asserted and `cpu_rw` = 1. `bus_wr` = DS asserted and `cpu_rw` = 0.
- R8: `cpu_ipl_n` is 3'b000 (level 7) when `bus_nmi` is high, 3'b110 (level 1) when only `bus_int` is high, and 3'b111 otherwise.
- R9: `halt_oe` and `reset_oe` are high while `rst_n` is low and low otherwise.
- R10: After reset the overlay is on. Each AS negation (`cpu_as_n` seen low on one clock edge and high on the next) counts one cycle, and the count takes effect after that edge. While fewer than 8 cycles have been counted, addresses 0x000000–0x07FFFF select `rom_cs[0]` and not `ram_cs[0]`.
- R11: Once 8 cycles have been counted, the overlay stays off for any further traffic until `rst_n` is asserted again, which turns it back on.
- R12: The overlay never changes the selects for 0x080000–0x0FFFFF or for any window other than RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| cpu_addr | input | 22 | Processor address |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_ds_n | input | 1 | Data strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| bus_nmi | input | 1 | Backplane non-maskable interrupt request, active high |
| bus_int | input | 1 | Backplane interrupt request, active high |
| cpu_ipl_n | output | 3 | Interrupt priority level, active low |
| cpu_dtack_n | output | 1 | Data transfer acknowledge, active low |
| cpu_vpa_n | output | 1 | Valid peripheral address, active low |
| bus_rd | output | 1 | Backplane read strobe |
| bus_wr | output | 1 | Backplane write strobe |
| ram_cs | output | 2 | RAM chip selects, active high |
| rom_cs | output | 2 | ROM chip selects, active high |
| bus_memrq | output | 1 | Backplane memory request |
| bus_iorq | output | 1 | Backplane I/O request |
| halt_oe | output | 1 | Enables the open-drain low drive on HALT |
| reset_oe | output | 1 | Enables the open-drain low drive on RESET |

## Verification
All decode, strobe, acknowledge, interrupt and open-drain enable outputs settle in the same cycle as the pin change, with no register in the path. The bench drives inputs one time unit after a rising edge and compares every output against its reference at the following falling edge. The overlay counter is the only registered result. An AS negation seen at one rising edge changes the overlay from the next falling edge onward. The reference model updates its own count at the same rising edges, so the eighth access is still overlaid and the ninth is not.

// File: rtl/glue68k_pkg.sv
package glue68k_pkg;

    localparam int ADDR_W = 22;

    // Top two address bits choose one of four 1MB windows
    typedef enum logic [1:0] {
        WIN_RAM   = 2'b00,
        WIN_ROM   = 2'b01,
        WIN_MEMRQ = 2'b10,
        WIN_IORQ  = 2'b11
    } win_t;

    typedef enum logic {
        BOOT_VECTOR = 1'b0,
        BOOT_RUN    = 1'b1
    } boot_state_t;

endpackage

// File: rtl/glue68k_decode.sv
module glue68k_decode
    import glue68k_pkg::*;
(
    input  logic [2:0] addr_hi,
    input  logic       as_act,
    input  logic       overlay,
    output logic [1:0] ram_cs,
    output logic [1:0] rom_cs,
    output logic       memrq,
    output logic       iorq,
    output logic       mem_win
);
    win_t win;
    logic bank;

    assign win  = win_t'(addr_hi[2:1]);
    assign bank = addr_hi[0];

    always_comb begin
        ram_cs  = 2'b00;
        rom_cs  = 2'b00;
        memrq   = 1'b0;
        iorq    = 1'b0;
        mem_win = 1'b0;
        if (as_act) begin
            unique case (win)
                WIN_RAM: begin
                    mem_win = 1'b1;
                    if (bank)         ram_cs[1] = 1'b1;
                    else if (overlay) rom_cs[0] = 1'b1;
                    else              ram_cs[0] = 1'b1;
                end
                WIN_ROM: begin
                    mem_win      = 1'b1;
                    rom_cs[bank] = 1'b1;
                end
                WIN_MEMRQ: begin
                    mem_win = 1'b1;
                    memrq   = 1'b1;
                end
                WIN_IORQ: iorq = 1'b1;
            endcase
        end
    end

    // R1
    always_comb begin
        at_most_one_select_chk: assert ($countones({ram_cs, rom_cs, memrq, iorq}) <= 1);
    end

endmodule

// File: rtl/glue68k_boot_overlay.sv
module glue68k_boot_overlay
    import glue68k_pkg::*;
#(
    parameter int VEC_FETCHES = 8,
    parameter int CNT_W       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_act,
    output logic overlay
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(VEC_FETCHES - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(VEC_FETCHES);

    boot_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             as_q;
    logic             cyc_end;

    assign cyc_end = as_q && !as_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BOOT_VECTOR;
            cnt   <= '0;
            as_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            as_q  <= as_act;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            BOOT_VECTOR: if (cyc_end) begin
                cnt_nx = cnt + 1'b1;
                if (cnt == LAST) state_nx = BOOT_RUN;
            end
            BOOT_RUN: cnt_nx = DONE;
        endcase
    end

    always_comb begin
        unique case (state)
            BOOT_VECTOR: overlay = 1'b1;
            BOOT_RUN:    overlay = 1'b0;
        endcase
    end

    // R11
    run_is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == BOOT_RUN |=> state == BOOT_RUN);

    // R10
    cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DONE);

    // R10
    vector_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BOOT_VECTOR && cyc_end && cnt != LAST) |=> state == BOOT_VECTOR);

endmodule

// File: rtl/glue68k_top.sv
module glue68k_top
    import glue68k_pkg::*;
#(
    parameter int VEC_FETCHES = 8,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_as_n,
    input  logic              cpu_ds_n,
    input  logic              cpu_rw,
    input  logic              bus_nmi,
    input  logic              bus_int,
    output logic [2:0]        cpu_ipl_n,
    output logic              cpu_dtack_n,
    output logic              cpu_vpa_n,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [1:0]        ram_cs,
    output logic [1:0]        rom_cs,
    output logic              bus_memrq,
    output logic              bus_iorq,
    output logic              halt_oe,
    output logic              reset_oe
);
    logic as_act, ds_act, overlay, mem_win;
    wire  unused_addr_lo = ^cpu_addr[ADDR_W-4:0];

    assign as_act = !cpu_as_n;
    assign ds_act = !cpu_ds_n;

    glue68k_boot_overlay #(.VEC_FETCHES(VEC_FETCHES), .CNT_W(CNT_W)) u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_act  (as_act),
        .overlay (overlay)
    );

    glue68k_decode u_dec (
        .addr_hi (cpu_addr[ADDR_W-1:ADDR_W-3]),
        .as_act  (as_act),
        .overlay (overlay),
        .ram_cs  (ram_cs),
        .rom_cs  (rom_cs),
        .memrq   (bus_memrq),
        .iorq    (bus_iorq),
        .mem_win (mem_win)
    );

    assign cpu_dtack_n = !(mem_win && ds_act);
    assign cpu_vpa_n   = !bus_iorq;
    assign bus_rd      = ds_act && cpu_rw;
    assign bus_wr      = ds_act && !cpu_rw;

    always_comb begin
        if (bus_nmi)      cpu_ipl_n = 3'b000;
        else if (bus_int) cpu_ipl_n = 3'b110;
        else              cpu_ipl_n = 3'b111;
    end

    assign halt_oe  = !rst_n;
    assign reset_oe = !rst_n;

    // R6
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cpu_dtack_n && !cpu_vpa_n));

    // R7
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R12
    upper_ram_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_act && cpu_addr[ADDR_W-1:ADDR_W-3] == 3'b001) |-> ram_cs[1]);

endmodule

// File: tb/glue68k_top_tb.sv
module glue68k_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] cpu_addr = '0;
    logic        cpu_as_n = 1'b1, cpu_ds_n = 1'b1, cpu_rw = 1'b1;
    logic        bus_nmi = 1'b0, bus_int = 1'b0;
    logic [2:0]  cpu_ipl_n;
    logic        cpu_dtack_n, cpu_vpa_n, bus_rd, bus_wr;
    logic [1:0]  ram_cs, rom_cs;
    logic        bus_memrq, bus_iorq, halt_oe, reset_oe;

    int tests = 0, fails = 0;
    int ref_cnt = 0;
    bit prev_as = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glue68k_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as_n(cpu_as_n),
        .cpu_ds_n(cpu_ds_n), .cpu_rw(cpu_rw), .bus_nmi(bus_nmi), .bus_int(bus_int),
        .cpu_ipl_n(cpu_ipl_n), .cpu_dtack_n(cpu_dtack_n), .cpu_vpa_n(cpu_vpa_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .ram_cs(ram_cs), .rom_cs(rom_cs),
        .bus_memrq(bus_memrq), .bus_iorq(bus_iorq), .halt_oe(halt_oe), .reset_oe(reset_oe)
    );

    // Reference count of completed strobe cycles (R10, R11)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= 0;
            prev_as <= 0;
        end else begin
            if (prev_as && cpu_as_n && ref_cnt < 8) ref_cnt <= ref_cnt + 1;
            prev_as <= !cpu_as_n;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the behavioural model at each falling edge
    always @(negedge clk) begin
        int a;
        bit as_on, ds_on, vec;
        int e_ram, e_rom, e_mrq, e_irq, e_dt, e_vpa, e_ipl;
        a = int'(cpu_addr);
        as_on = !cpu_as_n;
        ds_on = !cpu_ds_n;
        vec = (ref_cnt < 8);
        e_ram = 0; e_rom = 0; e_mrq = 0; e_irq = 0;
        if (as_on) begin
            if (a < 'h80000)        begin if (vec) e_rom = 1; else e_ram = 1; end
            else if (a < 'h100000)  e_ram = 2;
            else if (a < 'h180000)  e_rom = 1;
            else if (a < 'h200000)  e_rom = 2;
            else if (a < 'h300000)  e_mrq = 1;
            else                    e_irq = 1;
        end
        e_dt  = (as_on && ds_on && a < 'h300000) ? 0 : 1;
        e_vpa = (as_on && a >= 'h300000) ? 0 : 1;
        e_ipl = bus_nmi ? 0 : (bus_int ? 6 : 7);
        check("R1/R10/R12 ram_cs", ram_cs, e_ram);
        check("R2/R10 rom_cs", rom_cs, e_rom);
        check("R3/R4 bus_memrq", bus_memrq, e_mrq);
        check("R3/R4 bus_iorq", bus_iorq, e_irq);
        check("R5 cpu_dtack_n", cpu_dtack_n, e_dt);
        check("R6 cpu_vpa_n", cpu_vpa_n, e_vpa);
        check("R7 bus_rd", bus_rd, ds_on && cpu_rw);
        check("R7 bus_wr", bus_wr, ds_on && !cpu_rw);
        check("R8 cpu_ipl_n", cpu_ipl_n, e_ipl);
        check("R9 halt_oe", halt_oe, !rst_n);
        check("R9 reset_oe", reset_oe, !rst_n);
    end

    task automatic access(input logic [21:0] addr, input logic rw);
        @(posedge clk); #1;
        cpu_addr = addr; cpu_rw = rw; cpu_as_n = 1'b0;
        @(posedge clk); #1;
        cpu_ds_n = 1'b0;
        @(posedge clk); #1;
        cpu_as_n = 1'b1; cpu_ds_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic do_reset;
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        // R9: reset state, open-drain enables on, overlay armed
        check("R9 halt_oe in reset", halt_oe, 1);
        check("R4 idle ram_cs in reset", ram_cs, 0);
        #1 rst_n = 1'b1;
        // R10: eight vector fetches in the low RAM range come from ROM0
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            cpu_addr = 22'(i); cpu_rw = 1'b1; cpu_as_n = 1'b0;
            @(negedge clk);
            check("R10 overlay rom_cs", rom_cs, 1);
            check("R10 overlay ram_cs", ram_cs, 0);
            @(posedge clk); #1; cpu_ds_n = 1'b0;
            @(posedge clk); #1; cpu_as_n = 1'b1; cpu_ds_n = 1'b1;
        end
        // R11: ninth access sees RAM0
        @(posedge clk); #1;
        cpu_addr = 22'h000010; cpu_as_n = 1'b0;
        @(negedge clk);
        check("R11 ram0 after vectors", ram_cs, 1);
        check("R11 rom off after vectors", rom_cs, 0);
        @(posedge clk); #1; cpu_as_n = 1'b1;
        // Windows, strobes and acknowledges
        access(22'h000100, 1'b0);   // R1 RAM0 write
        access(22'h0A0000, 1'b1);   // R1 RAM1
        access(22'h120000, 1'b1);   // R2 ROM0
        access(22'h1F0000, 1'b1);   // R2 ROM1
        access(22'h280000, 1'b0);   // R3 memrq
        access(22'h3FFFFF, 1'b1);   // R3/R6 iorq
        access(22'h07FFFF, 1'b1);   // R1 top of RAM0
        // R4: address moves with AS negated
        @(posedge clk); #1; cpu_addr = 22'h150000;
        @(negedge clk);
        check("R4 no rom select without AS", rom_cs, 0);
        // R8: interrupt encodings
        @(posedge clk); #1; bus_int = 1'b1;
        @(negedge clk); check("R8 level 1", cpu_ipl_n, 3'b110);
        @(posedge clk); #1; bus_nmi = 1'b1;
        @(negedge clk); check("R8 level 7 wins", cpu_ipl_n, 3'b000);
        @(posedge clk); #1; bus_int = 1'b0;
        @(negedge clk); check("R8 level 7 only", cpu_ipl_n, 3'b000);
        @(posedge clk); #1; bus_nmi = 1'b0;
        // R11: reset re-arms the overlay
        do_reset;
        @(posedge clk); #1; cpu_addr = 22'h000004; cpu_as_n = 1'b0;
        @(negedge clk);
        check("R11 overlay re-armed", rom_cs, 1);
        // R12: upper RAM untouched during overlay
        @(posedge clk); #1; cpu_addr = 22'h0C0000;
        @(negedge clk);
        check("R12 ram1 during overlay", ram_cs, 2);
        @(posedge clk); #1; cpu_as_n = 1'b1;
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule